// File: doc/BRIEF.md
# Segment-List Pattern Sequencer

This block plays back a timed list of output patterns on 24 registered lines. The list lives in a small on-chip memory that a host fills through a simple write port. Each word is one of three kinds:

- an output step, which names a pattern and how many ticks to hold it;
- a loop step, which jumps back to an earlier index a set number of times;
- an end step, which closes the cycle and starts again from index 0.

A long hold therefore costs one word, whatever its length. A group of phases that repeats within a cycle is stored once and looped.

Time is counted in ticks. A built-in divider makes one tick every `CLK_PER_TICK` clocks, which is four clocks by default. It brings that tick out as a one-clock timebase strobe. A hold counter of 32 bits steps down once per tick. One loop counter serves the whole list, and loops do not nest. A cycle-start strobe marks each pass through an end step.

The sequencer runs while `run` is high. When `run` goes low the block returns to index 0, with its outputs and loop state cleared.

Top module: `seg_sequencer`

## Requirements
- R1: A host write with `wr_en` high stores the kind, pattern and operand at `wr_addr` on the next clock edge. The kind codes are 0 = output, 1 = loop and 2 = end; code 3 behaves exactly as end.
- R2: While `run` is high, `tick_o` is high for one clock in every `CLK_PER_TICK` clocks. The first tick comes `CLK_PER_TICK`-1 clocks after the edge that first samples `run` high. While `run` is low, `tick_o` stays low.
- R3: An output step with operand D drives its pattern on `seq_out` for exactly D ticks. The operand is 32 bits wide. A D of 0 is held for one tick.
- R4: A loop step uses operand bits [15:0] as the target index, taken modulo the memory depth, and bits [31:16] as a repeat count N. The loop body runs N+1 times in total, and N = 0 falls straight through. Each visit to the loop step costs one tick, with `seq_out` unchanged.
- R5: The single loop counter is loaded from N when a loop step is reached while no loop is in progress. After the last pass it is released, so the next visit reloads it. An end step also releases it, so every cycle repeats the same counts.
- R6: An end step costs one tick with `seq_out` unchanged, then continues from index 0. `cycle_start_o` is high for exactly the one clock that follows the edge on which the end step is taken.
- R7: While `run` is low, and after reset, `seq_out` and `cycle_start_o` are 0. When `run` rises, the first tick loads the word at index 0, and `seq_out` reads 0 until then.
- R8: `seq_out` changes only on the clock edge that ends a tick-strobe cycle, or when `run` is low.
- R9: After the last index the sequence continues at index 0 without an end step, and no `cycle_start_o` pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Level enable; low holds the sequencer at index 0 |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | IDX_W | Host write index |
| wr_kind | input | 2 | Step kind: 0 output, 1 loop, 2 or 3 end |
| wr_pattern | input | PAT_W | Output pattern of the step |
| wr_operand | input | 32 | Hold ticks, or loop target and count |
| seq_out | output | PAT_W | Registered pattern outputs |
| tick_o | output | 1 | Timebase strobe, one clock per tick |
| cycle_start_o | output | 1 | One-clock strobe after each end step |

## Verification
The bench reads `seq_out` once per tick and compares it against a tick-by-tick expansion of the same list, computed independently in the bench. The lists it plays are chosen so that each one can only match if one particular rule is right:

- a list of mixed durations that includes 0 and 1, which separates exact hold lengths from off-by-one timing;
- nested-looking loop ranges with counts 2 and 0, played over two cycles, which separate reload-on-entry from a counter that keeps its value across cycles;
- an eight-phase list closed by kind code 3, which checks that the reserved code acts as an end step and that cycle-start pulses fall on the right clock;
- a list that fills the whole memory with no end step, which tells wrap-around apart from a spurious cycle start.

Tick spacing is checked on every tick. The idle state is checked after each run, and each later run shows that the restart begins at index 0.

// File: rtl/seg_pkg.sv
package seg_pkg;

    localparam int OPND_W       = 32;
    localparam int LOOP_FIELD_W = 16;

    typedef enum logic [1:0] {
        SEG_OUT  = 2'd0,
        SEG_LOOP = 2'd1,
        SEG_END  = 2'd2,
        SEG_RSV  = 2'd3
    } seg_kind_e;

    typedef struct packed {
        seg_kind_e          kind;
        logic [OPND_W-1:0]  opnd;
    } seg_ctl_t;

    function automatic logic [LOOP_FIELD_W-1:0] loop_target(input logic [OPND_W-1:0] o);
        return o[LOOP_FIELD_W-1:0];
    endfunction

    function automatic logic [LOOP_FIELD_W-1:0] loop_count(input logic [OPND_W-1:0] o);
        return o[OPND_W-1 -: LOOP_FIELD_W];
    endfunction

    function automatic logic [OPND_W-1:0] hold_ticks(input logic [OPND_W-1:0] o);
        return (o == '0) ? OPND_W'(1) : o;
    endfunction

    function automatic logic is_end_kind(input seg_kind_e k);
        return (k == SEG_END) || (k == SEG_RSV);
    endfunction

endpackage

// File: rtl/seg_tickgen.sv
module seg_tickgen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_q <= '0;
        end else if (div_q == LAST) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + CW'(1);
        end
    end

    assign tick = (div_q == LAST);

    // R2
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && (DIV > 1)) |=> !tick);

    // R2
    idle_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && (DIV > 1)) |=> !tick);

endmodule

// File: rtl/seg_store.sv
module seg_store
    import seg_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int PAT_W = 24
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_addr,
    input  seg_ctl_t          wr_ctl,
    input  logic [PAT_W-1:0]  wr_pat,
    input  logic [IDX_W-1:0]  rd_idx,
    output seg_ctl_t          rd_ctl,
    output logic [PAT_W-1:0]  rd_pat
);
    localparam int DEPTH = 1 << IDX_W;

    seg_ctl_t         ctl_mem [DEPTH];
    logic [PAT_W-1:0] pat_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            ctl_mem[wr_addr] <= wr_ctl;
            pat_mem[wr_addr] <= wr_pat;
        end
    end

    assign rd_ctl = ctl_mem[rd_idx];
    assign rd_pat = pat_mem[rd_idx];

endmodule

// File: rtl/seg_holdcnt.sv
module seg_holdcnt #(
    parameter int DUR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              step,
    input  logic              load,
    input  logic [DUR_W-1:0]  load_val,
    output logic              done
);
    logic [DUR_W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            left_q <= '0;
        end else if (step) begin
            if (load) begin
                left_q <= load_val;
            end else if (left_q > DUR_W'(1)) begin
                left_q <= left_q - DUR_W'(1);
            end
        end
    end

    assign done = (left_q <= DUR_W'(1));

    // R3
    hold_countdown_chk: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !clear) |=> (left_q == $past(left_q) - DUR_W'(1)));

    // R3
    hold_load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (step && load && !clear) |=> (left_q != '0));

endmodule

// File: rtl/seg_loopunit.sv
module seg_loopunit #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              fire,
    input  logic [CNT_W-1:0]  count_in,
    output logic              take_jump
);
    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    assign take_jump = active_q ? (cnt_q != '0) : (count_in != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (fire) begin
            if (!active_q) begin
                if (count_in != '0) begin
                    active_q <= 1'b1;
                    cnt_q    <= count_in - CNT_W'(1);
                end
            end else if (cnt_q == '0) begin
                active_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
            end
        end
    end

    // R5
    loop_arm_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !clear && !active_q && (count_in != '0))
            |=> (active_q && (cnt_q == $past(count_in) - CNT_W'(1))));

    // R4
    loop_release_chk: assert property (@(posedge clk) disable iff (rst)
        (fire && !clear && active_q && (cnt_q == '0)) |=> !active_q);

    // R5
    loop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> !active_q);

endmodule

// File: rtl/seg_sequencer.sv
module seg_sequencer
    import seg_pkg::*;
#(
    parameter int IDX_W        = 6,
    parameter int PAT_W        = 24,
    parameter int CLK_PER_TICK = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [1:0]         wr_kind,
    input  logic [PAT_W-1:0]   wr_pattern,
    input  logic [OPND_W-1:0]  wr_operand,
    output logic [PAT_W-1:0]   seq_out,
    output logic               tick_o,
    output logic               cycle_start_o
);
    localparam int DEPTH = 1 << IDX_W;

    logic [IDX_W-1:0]        pc_q;
    logic [PAT_W-1:0]        out_q;
    logic                    cs_q;
    logic                    tick;
    logic                    step;
    logic                    hold_done;
    logic                    load;
    logic                    take_jump;
    seg_ctl_t                wr_ctl;
    seg_ctl_t                cur_ctl;
    logic [PAT_W-1:0]        cur_pat;
    logic                    is_out;
    logic                    is_loop;
    logic                    is_end;
    logic [OPND_W-1:0]       hold_val;
    logic [LOOP_FIELD_W-1:0] tgt_raw;
    logic [IDX_W-1:0]        tgt_idx;
    logic [IDX_W-1:0]        pc_next;

    assign wr_ctl = '{kind: seg_kind_e'(wr_kind), opnd: wr_operand};

    seg_tickgen #(.DIV(CLK_PER_TICK)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick)
    );

    seg_store #(.IDX_W(IDX_W), .PAT_W(PAT_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_ctl  (wr_ctl),
        .wr_pat  (wr_pattern),
        .rd_idx  (pc_q),
        .rd_ctl  (cur_ctl),
        .rd_pat  (cur_pat)
    );

    assign step    = tick && run;
    assign load    = step && hold_done;
    assign is_out  = (cur_ctl.kind == SEG_OUT);
    assign is_loop = (cur_ctl.kind == SEG_LOOP);
    assign is_end  = is_end_kind(cur_ctl.kind);

    assign hold_val = is_out ? hold_ticks(cur_ctl.opnd) : OPND_W'(1);

    seg_holdcnt #(.DUR_W(OPND_W)) u_hold (
        .clk      (clk),
        .rst      (rst),
        .clear    (!run),
        .step     (step),
        .load     (load),
        .load_val (hold_val),
        .done     (hold_done)
    );

    seg_loopunit #(.CNT_W(LOOP_FIELD_W)) u_loop (
        .clk       (clk),
        .rst       (rst),
        .clear     (!run || (load && is_end)),
        .fire      (load && is_loop),
        .count_in  (loop_count(cur_ctl.opnd)),
        .take_jump (take_jump)
    );

    assign tgt_raw = loop_target(cur_ctl.opnd);
    assign tgt_idx = IDX_W'(tgt_raw % LOOP_FIELD_W'(DEPTH));

    always_comb begin
        pc_next = pc_q + IDX_W'(1);
        if (is_end) begin
            pc_next = '0;
        end else if (is_loop && take_jump) begin
            pc_next = tgt_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            pc_q  <= '0;
            out_q <= '0;
            cs_q  <= 1'b0;
        end else begin
            cs_q <= load && is_end;
            if (load) begin
                pc_q <= pc_next;
                if (is_out) begin
                    out_q <= cur_pat;
                end
            end
        end
    end

    assign seq_out       = out_q;
    assign tick_o        = tick;
    assign cycle_start_o = cs_q;

    // R6
    cycle_after_step_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_start_o |-> $past(step));

    // R6
    cycle_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        cycle_start_o |-> (pc_q == '0));

    // R6
    cycle_single_chk: assert property (@(posedge clk) disable iff (rst)
        (cycle_start_o && (CLK_PER_TICK > 1)) |=> !cycle_start_o);

    // R7
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> ((seq_out == '0) && !cycle_start_o));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !step) |=> $stable(seq_out));

endmodule

// File: tb/seg_sequencer_bench.sv
module seg_sequencer_bench;
    import seg_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 4;
    localparam int DEPTH      = 1 << IDX_W;
    localparam int PAT_W      = 24;
    localparam int TICK_DIV   = 4;
    localparam int MAXN       = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              run = 1'b0;
    logic              wr_en = 1'b0;
    logic [IDX_W-1:0]  wr_addr = '0;
    logic [1:0]        wr_kind = '0;
    logic [PAT_W-1:0]  wr_pattern = '0;
    logic [31:0]       wr_operand = '0;
    logic [PAT_W-1:0]  seq_out;
    logic              tick_o;
    logic              cycle_start_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    logic [1:0]       b_kind [DEPTH];
    logic [PAT_W-1:0] b_pat  [DEPTH];
    logic [31:0]      b_op   [DEPTH];
    logic [PAT_W-1:0] e_pat  [MAXN];
    bit               e_end  [MAXN];

    seg_sequencer #(
        .IDX_W(IDX_W), .PAT_W(PAT_W), .CLK_PER_TICK(TICK_DIV)
    ) u_seg_sequencer (
        .clk(clk), .rst(rst), .run(run),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_kind(wr_kind),
        .wr_pattern(wr_pattern), .wr_operand(wr_operand),
        .seq_out(seq_out), .tick_o(tick_o), .cycle_start_o(cycle_start_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic put(input int a, input logic [1:0] k,
                       input logic [PAT_W-1:0] p, input logic [31:0] o);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = IDX_W'(a); wr_kind = k; wr_pattern = p; wr_operand = o;
        @(negedge clk);
        wr_en = 1'b0;
        b_kind[a] = k; b_pat[a] = p; b_op[a] = o;
    endtask

    // Expected per-tick pattern list derived from the requirements
    task automatic build(input int n);
        int pc = 0;
        int i  = 0;
        logic [PAT_W-1:0] cur = '0;
        bit act = 1'b0;
        int cnt = 0;
        while (i < n) begin
            if (b_kind[pc] == 2'd0) begin
                longint d = (b_op[pc] == 0) ? 1 : longint'(b_op[pc]);
                for (longint j = 0; j < d && i < n; j++) begin
                    e_pat[i] = b_pat[pc]; e_end[i] = 1'b0; i++;
                end
                cur = b_pat[pc];
                pc = (pc + 1) % DEPTH;
            end else if (b_kind[pc] == 2'd1) begin
                int tgt = int'(b_op[pc][15:0]) % DEPTH;
                int c   = int'(b_op[pc][31:16]);
                e_pat[i] = cur; e_end[i] = 1'b0; i++;
                if (!act) begin
                    if (c != 0) begin act = 1'b1; cnt = c - 1; pc = tgt; end
                    else pc = (pc + 1) % DEPTH;
                end else if (cnt == 0) begin
                    act = 1'b0; pc = (pc + 1) % DEPTH;
                end else begin
                    cnt--; pc = tgt;
                end
            end else begin
                e_pat[i] = cur; e_end[i] = 1'b1; i++;
                pc = 0; act = 1'b0;
            end
        end
    endtask

    task automatic run_prog(input int n, input string req);
        int k = 0;
        int since = 0;
        bit pend = 1'b0;
        build(n + 1);
        @(negedge clk);
        run = 1'b1;
        while (k <= n) begin
            @(negedge clk);
            since++;
            check(cycle_start_o == pend, "R6", "cycle_start", 64'(cycle_start_o), 64'(pend));
            pend = 1'b0;
            if (tick_o) begin
                if (k == 0) begin
                    // R7: first tick still shows the idle pattern
                    check(seq_out == '0, "R7", "first tick", 64'(seq_out), 64'd0);
                end else begin
                    check(seq_out == e_pat[k-1], req, "tick pattern", 64'(seq_out), 64'(e_pat[k-1]));
                    check(since == TICK_DIV, "R2", "tick spacing", 64'(since), 64'(TICK_DIV));
                end
                since = 0;
                pend = e_end[k];
                k++;
            end
        end
        run = 1'b0;
        @(negedge clk);
        check(seq_out == '0, "R7", "idle outputs", 64'(seq_out), 64'd0);
        check(cycle_start_o == 1'b0, "R7", "idle cycle_start", 64'(cycle_start_o), 64'd0);
        check(tick_o == 1'b0, "R2", "idle tick", 64'(tick_o), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(seq_out == '0, "R7", "reset outputs", 64'(seq_out), 64'd0);
        check(tick_o == 1'b0, "R2", "reset tick", 64'(tick_o), 64'd0);
        check(cycle_start_o == 1'b0, "R6", "reset cycle_start", 64'(cycle_start_o), 64'd0);

        // R3 durations 3, 0, 1, 2 then end (R1 code 2)
        put(0, 2'd0, 24'h000001, 32'd3);
        put(1, 2'd0, 24'h000F00, 32'd0);
        put(2, 2'd0, 24'hABCDEF, 32'd1);
        put(3, 2'd0, 24'h800000, 32'd2);
        put(4, 2'd2, 24'h000000, 32'd0);
        run_prog(20, "R3");

        // R4 / R5 loop ranges: count 2 then count 0, played across two cycles
        put(0, 2'd0, 24'h000011, 32'd2);
        put(1, 2'd0, 24'h000022, 32'd1);
        put(2, 2'd1, 24'hFFFFFF, {16'd2, 16'd0});
        put(3, 2'd0, 24'h000033, 32'd1);
        put(4, 2'd1, 24'hFFFFFF, {16'd0, 16'd3});
        put(5, 2'd2, 24'h000000, 32'd0);
        run_prog(34, "R4_R5");

        // R1 eight phases closed by code 3 acting as end
        for (int i = 0; i < 8; i++) begin
            put(i, 2'd0, PAT_W'(24'h7 << (3 * i)), 32'((i % 3) + 1));
        end
        put(8, 2'd3, 24'h000000, 32'd0);
        run_prog(40, "R1");

        // R9 full memory with no end step wraps to index 0
        for (int i = 0; i < DEPTH; i++) begin
            put(i, 2'd0, PAT_W'(24'h100 + i), 32'd1);
        end
        run_prog(40, "R9");

        // R8 restart after idle replays from index 0
        run_prog(20, "R8");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule